// File: doc/BRIEF.md
# Tagged token matching unit

This block is the pairing stage of a tagged-token dataflow processor. Each incoming token names a destination instruction and an iteration tag. It also carries an operand port number (0 or 1), an arity flag and a data word. If the destination instruction takes a single operand, the token skips the store and goes straight to the fetch output. If the destination takes two operands, the token waits in a set-associative matching store until its partner arrives. The partner has the same destination and tag but the opposite port, and the unit then sends both operands to the fetch stage as one packet.

The store is indexed by a small hash of the destination and the tag. Each set holds `WAYS` waiting tokens, 16 by default. A token that finds no partner and no free way in its set goes to a separate overflow output. The storage behind that overflow output lies outside this block. The unit takes one token at a time over a valid/ready handshake. It holds a result on its output until the downstream stage takes it.

Top module: `token_match_unit`

## Requirements
- R1: After reset both outputs are invalid, the input is ready and the matching store holds no tokens.
- R2: A token with arity flag 0 goes to the fetch output, valid at the clock edge that accepts it, with pair flag 0, operand 0 equal to its data and operand 1 equal to zero; the store is untouched.
- R3: A token with arity flag 1 whose partner is not in the store is written into the store and produces no output.
- R4: A token with arity flag 1 whose partner (same destination, same tag, opposite port) is stored produces one fetch packet one clock after acceptance, with pair flag 1, operand 0 from the port-0 token and operand 1 from the port-1 token; the partner entry is freed.
- R5: Stored tokens that differ from the incoming one in destination or tag, or that use the same port, are not paired with it.
- R6: The set index is destination bits [1:0] XOR tag bits [1:0]. A set holds 16 waiting tokens. A further unmatched token for a full set appears unchanged on the overflow output one clock after acceptance.
- R7: While an output is valid and not taken, its fields stay stable and the input is not ready. The input is also not ready during a store lookup.
- R8: When several stored tokens in a set match, the one written earliest into the lowest-numbered way is paired first.
- R9: A way freed by a match is reused by the next token that must wait in that set.
- R10: Operand pairs arriving in any interleaving across several destinations and tags each produce exactly one fetch packet with the correct operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Incoming token valid |
| in_ready_o | output | 1 | Unit can accept a token |
| in_dest_i | input | ADDR_W | Destination instruction address |
| in_tag_i | input | TAG_W | Iteration tag |
| in_port_i | input | 1 | Operand port (0 or 1) |
| in_dual_i | input | 1 | 1: destination takes two operands |
| in_data_i | input | DATA_W | Operand value |
| fetch_valid_o | output | 1 | Fetch packet valid |
| fetch_ready_i | input | 1 | Fetch stage takes the packet |
| fetch_dest_o | output | ADDR_W | Packet destination |
| fetch_tag_o | output | TAG_W | Packet tag |
| fetch_pair_o | output | 1 | 1: two operands present |
| fetch_op0_o | output | DATA_W | Port-0 operand (or single operand) |
| fetch_op1_o | output | DATA_W | Port-1 operand (zero for single) |
| ovf_valid_o | output | 1 | Overflow token valid |
| ovf_ready_i | input | 1 | Overflow path takes the token |
| ovf_dest_o | output | ADDR_W | Overflow token destination |
| ovf_tag_o | output | TAG_W | Overflow token tag |
| ovf_port_o | output | 1 | Overflow token port |
| ovf_data_o | output | DATA_W | Overflow token value |

## Verification
The pairing function is driven with several input orders. Port 0 and port 1 tokens are interleaved in a shuffled order. In a second round all port-1 tokens arrive before any port-0 token, which shows that the operand order is set by the port number and not by arrival order. Tokens that share a destination but differ in tag or port show that the key compare is complete. Two identical port-0 tokens are used to expose which way wins when several entries match. A set is filled with 16 unrelated tokens, and further tokens then separate overflow from storage and confirm that a freed way is reused. A stalled fetch stage checks that the output holds and that the input waits.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  typedef enum logic {ST_IDLE, ST_LOOK} tmu_state_e;
endpackage

// File: rtl/tmu_set_hash.sv
module tmu_set_hash #(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 4,
  parameter int SET_W  = 2
) (
  input  logic [ADDR_W-1:0] dest_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [SET_W-1:0]  set_o
);
  assign set_o = dest_i[SET_W-1:0] ^ tag_i[SET_W-1:0];
endmodule

// File: rtl/tmu_way_pick.sv
module tmu_way_pick #(
  parameter int WAYS  = 16,
  parameter int KEY_W = 12,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][KEY_W-1:0] key_i,
  input  logic [WAYS-1:0]            port_i,
  input  logic [KEY_W-1:0]           probe_key_i,
  input  logic                       probe_port_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output logic                       free_o,
  output logic [WAY_W-1:0]           free_way_o
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = vld_i[g] && (key_i[g] == probe_key_i) && (port_i[g] != probe_port_i);
  end

  // lowest index wins: scan downward, last assignment sticks
  always_comb begin
    hit_o      = 1'b0;
    hit_way_o  = '0;
    free_o     = 1'b0;
    free_way_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(i);
      end
      if (!vld_i[i]) begin
        free_o     = 1'b1;
        free_way_o = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/tmu_store.sv
module tmu_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 16,
  parameter int KEY_W  = 12,
  parameter int DATA_W = 16,
  parameter int SET_W  = $clog2(SETS),
  parameter int WAY_W  = $clog2(WAYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [SET_W-1:0]            set_i,
  output logic [WAYS-1:0]             vld_o,
  output logic [WAYS-1:0][KEY_W-1:0]  key_o,
  output logic [WAYS-1:0]             port_o,
  output logic [WAYS-1:0][DATA_W-1:0] data_o,
  input  logic                        wr_en_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic [KEY_W-1:0]            wr_key_i,
  input  logic                        wr_port_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic                        clr_en_i,
  input  logic [WAY_W-1:0]            clr_way_i
);
  logic [SETS-1:0][WAYS-1:0]  vld_q;
  logic [WAYS-1:0][KEY_W-1:0]  key_q  [SETS];
  logic [WAYS-1:0]             port_q [SETS];
  logic [WAYS-1:0][DATA_W-1:0] data_q [SETS];

  assign vld_o  = vld_q[set_i];
  assign key_o  = key_q[set_i];
  assign port_o = port_q[set_i];
  assign data_o = data_q[set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      if (wr_en_i)  vld_q[set_i][wr_way_i]  <= 1'b1;
      if (clr_en_i) vld_q[set_i][clr_way_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      key_q[set_i][wr_way_i]  <= wr_key_i;
      port_q[set_i][wr_way_i] <= wr_port_i;
      data_q[set_i][wr_way_i] <= wr_data_i;
    end
  end

  p_wr_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !vld_q[set_i][wr_way_i]);
  p_clr_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |-> vld_q[set_i][clr_way_i]);
  p_clr_gone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> !vld_q[$past(set_i)][$past(clr_way_i)]);
  p_wr_clr_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && clr_en_i));
endmodule

// File: rtl/token_match_unit.sv
module token_match_unit #(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int SET_W  = 2,
  parameter int WAYS   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] in_dest_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  input  logic              in_port_i,
  input  logic              in_dual_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              fetch_valid_o,
  input  logic              fetch_ready_i,
  output logic [ADDR_W-1:0] fetch_dest_o,
  output logic [TAG_W-1:0]  fetch_tag_o,
  output logic              fetch_pair_o,
  output logic [DATA_W-1:0] fetch_op0_o,
  output logic [DATA_W-1:0] fetch_op1_o,
  output logic              ovf_valid_o,
  input  logic              ovf_ready_i,
  output logic [ADDR_W-1:0] ovf_dest_o,
  output logic [TAG_W-1:0]  ovf_tag_o,
  output logic              ovf_port_o,
  output logic [DATA_W-1:0] ovf_data_o
);
  import tmu_pkg::*;

  localparam int SETS  = 1 << SET_W;
  localparam int KEY_W = ADDR_W + TAG_W;
  localparam int WAY_W = $clog2(WAYS);

  tmu_state_e        state_q;
  logic [ADDR_W-1:0] tok_dest_q;
  logic [TAG_W-1:0]  tok_tag_q;
  logic              tok_port_q;
  logic [DATA_W-1:0] tok_data_q;

  logic [SET_W-1:0]            set_idx;
  logic [WAYS-1:0]             rd_vld;
  logic [WAYS-1:0][KEY_W-1:0]  rd_key;
  logic [WAYS-1:0]             rd_port;
  logic [WAYS-1:0][DATA_W-1:0] rd_data;
  logic                        hit, free;
  logic [WAY_W-1:0]            hit_way, free_way;
  logic                        accept, looking, wr_en, clr_en;
  logic [DATA_W-1:0]           partner;

  tmu_set_hash #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .SET_W(SET_W)) u_hash (
    .dest_i(tok_dest_q), .tag_i(tok_tag_q), .set_o(set_idx)
  );

  tmu_store #(.SETS(SETS), .WAYS(WAYS), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .set_i(set_idx), .vld_o(rd_vld), .key_o(rd_key), .port_o(rd_port), .data_o(rd_data),
    .wr_en_i(wr_en), .wr_way_i(free_way), .wr_key_i({tok_dest_q, tok_tag_q}),
    .wr_port_i(tok_port_q), .wr_data_i(tok_data_q),
    .clr_en_i(clr_en), .clr_way_i(hit_way)
  );

  tmu_way_pick #(.WAYS(WAYS), .KEY_W(KEY_W)) u_pick (
    .vld_i(rd_vld), .key_i(rd_key), .port_i(rd_port),
    .probe_key_i({tok_dest_q, tok_tag_q}), .probe_port_i(tok_port_q),
    .hit_o(hit), .hit_way_o(hit_way), .free_o(free), .free_way_o(free_way)
  );

  assign in_ready_o = (state_q == ST_IDLE) && (!fetch_valid_o || fetch_ready_i)
                                           && (!ovf_valid_o || ovf_ready_i);
  assign accept  = in_valid_i && in_ready_o;
  assign looking = (state_q == ST_LOOK);
  assign clr_en  = looking && hit;
  assign wr_en   = looking && !hit && free;
  assign partner = rd_data[hit_way];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      tok_dest_q    <= '0;
      tok_tag_q     <= '0;
      tok_port_q    <= 1'b0;
      tok_data_q    <= '0;
      fetch_valid_o <= 1'b0;
      fetch_dest_o  <= '0;
      fetch_tag_o   <= '0;
      fetch_pair_o  <= 1'b0;
      fetch_op0_o   <= '0;
      fetch_op1_o   <= '0;
      ovf_valid_o   <= 1'b0;
      ovf_dest_o    <= '0;
      ovf_tag_o     <= '0;
      ovf_port_o    <= 1'b0;
      ovf_data_o    <= '0;
    end else begin
      if (fetch_valid_o && fetch_ready_i) fetch_valid_o <= 1'b0;
      if (ovf_valid_o && ovf_ready_i)     ovf_valid_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (!in_dual_i) begin
            fetch_valid_o <= 1'b1;
            fetch_dest_o  <= in_dest_i;
            fetch_tag_o   <= in_tag_i;
            fetch_pair_o  <= 1'b0;
            fetch_op0_o   <= in_data_i;
            fetch_op1_o   <= '0;
          end else begin
            tok_dest_q <= in_dest_i;
            tok_tag_q  <= in_tag_i;
            tok_port_q <= in_port_i;
            tok_data_q <= in_data_i;
            state_q    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          state_q <= ST_IDLE;
          if (hit) begin
            fetch_valid_o <= 1'b1;
            fetch_dest_o  <= tok_dest_q;
            fetch_tag_o   <= tok_tag_q;
            fetch_pair_o  <= 1'b1;
            fetch_op0_o   <= tok_port_q ? partner : tok_data_q;
            fetch_op1_o   <= tok_port_q ? tok_data_q : partner;
          end else if (!free) begin
            ovf_valid_o <= 1'b1;
            ovf_dest_o  <= tok_dest_q;
            ovf_tag_o   <= tok_tag_q;
            ovf_port_o  <= tok_port_q;
            ovf_data_o  <= tok_data_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_bypass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !in_dual_i |=> fetch_valid_o && !fetch_pair_o && fetch_op0_o == $past(in_data_i));
  p_fetch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o && !fetch_ready_i |=> fetch_valid_o
      && $stable({fetch_dest_o, fetch_tag_o, fetch_pair_o, fetch_op0_o, fetch_op1_o}));
  p_ovf_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_valid_o && !ovf_ready_i |=> ovf_valid_o
      && $stable({ovf_dest_o, ovf_tag_o, ovf_port_o, ovf_data_o}));
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_valid_o) |-> $past($countones(rd_vld)) == WAYS);
  p_out_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_valid_o && ovf_valid_o));
endmodule

// File: tb/tb_token_match_unit.sv
`timescale 1ns/1ps
module tb_token_match_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 1'b0, in_ready, in_port = 1'b0, in_dual = 1'b0;
  logic [7:0]  in_dest = '0;
  logic [3:0]  in_tag = '0;
  logic [15:0] in_data = '0;
  logic        f_valid, f_ready = 1'b1, f_pair;
  logic [7:0]  f_dest;
  logic [3:0]  f_tag;
  logic [15:0] f_op0, f_op1;
  logic        o_valid, o_ready = 1'b1, o_port;
  logic [7:0]  o_dest;
  logic [3:0]  o_tag;
  logic [15:0] o_data;

  token_match_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_dest_i(in_dest), .in_tag_i(in_tag),
    .in_port_i(in_port), .in_dual_i(in_dual), .in_data_i(in_data),
    .fetch_valid_o(f_valid), .fetch_ready_i(f_ready), .fetch_dest_o(f_dest), .fetch_tag_o(f_tag),
    .fetch_pair_o(f_pair), .fetch_op0_o(f_op0), .fetch_op1_o(f_op1),
    .ovf_valid_o(o_valid), .ovf_ready_i(o_ready), .ovf_dest_o(o_dest), .ovf_tag_o(o_tag),
    .ovf_port_o(o_port), .ovf_data_o(o_data)
  );

  int checks = 0, failures = 0;
  int log_n = 0, ov_n = 0;
  logic [7:0]  lg_dest [256];
  logic [3:0]  lg_tag  [256];
  logic        lg_pair [256];
  logic [15:0] lg_op0  [256];
  logic [15:0] lg_op1  [256];

  // sample handshakes late in the cycle, inputs settled since the falling edge
  always @(negedge clk) begin
    #8;
    if (f_valid && f_ready && log_n < 256) begin
      lg_dest[log_n] = f_dest; lg_tag[log_n] = f_tag; lg_pair[log_n] = f_pair;
      lg_op0[log_n] = f_op0;   lg_op1[log_n] = f_op1;
      log_n++;
    end
    if (o_valid && o_ready) ov_n++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [3:0] t, input logic p,
                      input logic du, input logic [15:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_dest = d; in_tag = t; in_port = p; in_dual = du; in_data = v;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(f_valid == 1'b0, "R1", "fetch_valid after reset", f_valid, 0);
    chk(o_valid == 1'b0, "R1", "ovf_valid after reset", o_valid, 0);
  endtask

  task automatic t_bypass;
    int n0;
    n0 = log_n;
    send(8'h21, 4'h3, 1'b1, 1'b0, 16'hBEEF);
    chk(f_valid == 1'b1, "R2", "bypass valid one edge after accept", f_valid, 1);
    chk(f_pair == 1'b0, "R2", "bypass pair flag", f_pair, 0);
    chk(f_op0 == 16'hBEEF, "R2", "bypass op0", f_op0, 16'hBEEF);
    chk(f_op1 == 16'h0, "R2", "bypass op1", f_op1, 0);
    chk(f_dest == 8'h21 && f_tag == 4'h3, "R2", "bypass dest/tag", {f_dest, f_tag}, {8'h21, 4'h3});
    idle(3);
    chk(log_n == n0 + 1, "R2", "bypass packet count", log_n - n0, 1);
  endtask

  task automatic t_pair;
    int n0;
    n0 = log_n;
    send(8'h35, 4'h7, 1'b1, 1'b1, 16'h1111);
    idle(3);
    chk(log_n == n0, "R3", "lone token produces nothing", log_n - n0, 0);
    chk(o_valid == 1'b0, "R3", "lone token not overflowed", o_valid, 0);
    send(8'h35, 4'h7, 1'b0, 1'b1, 16'h2222);
    chk(f_valid == 1'b0, "R4", "pair not yet valid at first edge", f_valid, 0);
    @(negedge clk);
    chk(f_valid == 1'b1 && f_pair == 1'b1, "R4", "pair valid and flagged", {f_valid, f_pair}, 2'b11);
    chk(f_op0 == 16'h2222, "R4", "op0 from port 0", f_op0, 16'h2222);
    chk(f_op1 == 16'h1111, "R4", "op1 from port 1", f_op1, 16'h1111);
    idle(3);
    n0 = log_n;
    send(8'h35, 4'h7, 1'b0, 1'b1, 16'h3333);
    idle(3);
    chk(log_n == n0, "R4", "partner entry freed after match", log_n - n0, 0);
    send(8'h35, 4'h7, 1'b1, 1'b1, 16'h4444);
    idle(3);
    chk(log_n == n0 + 1 && lg_op0[n0] == 16'h3333 && lg_op1[n0] == 16'h4444, "R4",
        "re-pair after free", {lg_op0[n0], lg_op1[n0]}, {16'h3333, 16'h4444});
  endtask

  task automatic t_nomatch;
    int n0;
    n0 = log_n;
    send(8'h50, 4'h2, 1'b0, 1'b1, 16'hA001);
    send(8'h50, 4'h2, 1'b0, 1'b1, 16'hA002); // same port
    send(8'h50, 4'h3, 1'b1, 1'b1, 16'hA003); // other tag
    send(8'h51, 4'h2, 1'b1, 1'b1, 16'hA004); // other dest
    idle(3);
    chk(log_n == n0, "R5", "no pairing on key or port mismatch", log_n - n0, 0);
    send(8'h50, 4'h3, 1'b0, 1'b1, 16'hA005);
    send(8'h51, 4'h2, 1'b0, 1'b1, 16'hA006);
    idle(3);
    chk(log_n == n0 + 2 && lg_op1[n0] == 16'hA003 && lg_op1[n0+1] == 16'hA004, "R5",
        "tag and dest partners resolved", {lg_op1[n0], lg_op1[n0+1]}, {16'hA003, 16'hA004});
    send(8'h50, 4'h2, 1'b1, 1'b1, 16'hA007);
    idle(3);
    chk(lg_op0[n0+2] == 16'hA001, "R8", "lowest way paired first", lg_op0[n0+2], 16'hA001);
    send(8'h50, 4'h2, 1'b1, 1'b1, 16'hA008);
    idle(3);
    chk(lg_op0[n0+3] == 16'hA002, "R8", "second way paired next", lg_op0[n0+3], 16'hA002);
  endtask

  function automatic logic [15:0] dval(input int r, input int k, input int p);
    return 16'((r << 12) | (k << 4) | p);
  endfunction

  task automatic t_random(input int rnd);
    int ord [24];
    int n0, hits, at;
    n0 = log_n;
    for (int i = 0; i < 24; i++) ord[i] = (rnd == 0) ? i : ((i < 12) ? (2*i + 1) : (2*(i-12)));
    if (rnd == 0)
      for (int i = 23; i > 0; i--) begin
        int j, tmp;
        j = $urandom_range(i, 0);
        tmp = ord[i]; ord[i] = ord[j]; ord[j] = tmp;
      end
    for (int i = 0; i < 24; i++) begin
      int k, p;
      k = ord[i] / 2; p = ord[i] % 2;
      send(8'(8'h80 + rnd*16 + k), 4'(k + rnd), 1'(p), 1'b1, dval(rnd, k, p));
    end
    idle(4);
    chk(log_n == n0 + 12, "R10", "packet count per round", log_n - n0, 12);
    for (int k = 0; k < 12; k++) begin
      hits = 0; at = n0;
      for (int e = n0; e < log_n; e++)
        if (lg_dest[e] == 8'(8'h80 + rnd*16 + k) && lg_tag[e] == 4'(k + rnd)) begin
          hits++; at = e;
        end
      chk(hits == 1, "R10", "pair emitted exactly once", hits, 1);
      chk(lg_pair[at] && lg_op0[at] == dval(rnd, k, 0) && lg_op1[at] == dval(rnd, k, 1), "R10",
          "pair operands", {lg_op0[at], lg_op1[at]}, {dval(rnd, k, 0), dval(rnd, k, 1)});
    end
  endtask

  task automatic t_overflow;
    int n0, v0;
    n0 = log_n; v0 = ov_n;
    for (int t = 0; t < 16; t++)
      send({6'h28, 2'(t)}, 4'(t), 1'b0, 1'b1, 16'(16'hC000 + t)); // set 0
    idle(3);
    chk(log_n == n0 && ov_n == v0, "R6", "sixteen tokens fit in one set", ov_n - v0, 0);
    send(8'hA4, 4'h0, 1'b0, 1'b1, 16'hC0DE);
    chk(o_valid == 1'b0, "R6", "overflow not valid at first edge", o_valid, 0);
    @(negedge clk);
    chk(o_valid == 1'b1, "R6", "seventeenth token overflows", o_valid, 1);
    chk(o_dest == 8'hA4 && o_tag == 4'h0 && o_port == 1'b0 && o_data == 16'hC0DE, "R6",
        "overflow fields", {o_dest, o_tag, o_port, o_data}, {8'hA4, 4'h0, 1'b0, 16'hC0DE});
    chk(f_valid == 1'b0, "R6", "no fetch on overflow", f_valid, 0);
    idle(2);
    send(8'hA3, 4'h3, 1'b1, 1'b1, 16'hD003);
    idle(3);
    chk(log_n == n0 + 1 && lg_op0[n0] == 16'hC003, "R9", "match frees a way",
        lg_op0[n0], 16'hC003);
    v0 = ov_n;
    send(8'hA8, 4'h0, 1'b0, 1'b1, 16'hE000);
    idle(3);
    chk(ov_n == v0 && log_n == n0 + 1, "R9", "freed way reused, no overflow", ov_n - v0, 0);
    send(8'hA8, 4'h0, 1'b1, 1'b1, 16'hE001);
    idle(3);
    chk(log_n == n0 + 2 && lg_op0[n0+1] == 16'hE000 && lg_op1[n0+1] == 16'hE001, "R9",
        "token in reused way pairs", {lg_op0[n0+1], lg_op1[n0+1]}, {16'hE000, 16'hE001});
  endtask

  task automatic t_stall;
    int n0;
    n0 = log_n;
    @(negedge clk);
    f_ready = 1'b0;
    send(8'h11, 4'h1, 1'b0, 1'b0, 16'h5A5A);
    in_valid = 1'b1; in_dest = 8'h12; in_tag = 4'h2; in_port = 1'b0; in_dual = 1'b0;
    in_data = 16'h6B6B;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R7", "input held off while fetch stalled", in_ready, 0);
      chk(f_valid == 1'b1 && f_op0 == 16'h5A5A, "R7", "stalled packet stable", f_op0, 16'h5A5A);
    end
    f_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(f_valid == 1'b1 && f_op0 == 16'h6B6B, "R7", "queued token accepted on release",
        f_op0, 16'h6B6B);
    idle(3);
    chk(log_n == n0 + 2 && lg_op0[n0] == 16'h5A5A, "R7", "stalled packet delivered once",
        log_n - n0, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_pair();
    t_nomatch();
    t_random(0);
    t_random(1);
    t_overflow();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule